// File: doc/BRIEF.md
# Decrementing Timer and Event Counter

This block holds a 16-bit down-counter and a reload register at one word address on the processor's memory bus. A bus write at that address loads the same value into both the live count and the reload register. A bus read at that address returns the live count. Each trigger lowers the count by one. When the count reaches zero, it is refilled from the reload register and, if enabled, a timer interrupt is posted.

A mode input chooses where the triggers come from. With the mode clear, triggers come from the system clock through a fixed prescaler, but only while the enable input is set. In this mode the external pin works as a level interrupt request of its own. With the mode set, the same pin becomes an event input: each rising edge, once synchronized, is one trigger, and the pin no longer produces an interrupt request. Arbitration between interrupt sources happens elsewhere.

Top module: `dec_event_timer`

## Requirements
- R1: After reset the count and reload value are 0, and tmr_flag, tmr_req and ext_irq are low.
- R2: A write with bus_addr equal to 0xFFFA or 0xFFFB (bit 0 ignored) loads bus_wdata into both the count and the reload register on that clock edge. A write to any other address changes neither.
- R3: While bus_rd is high and bus_addr matches as in R2, bus_rdata shows the current count in the same cycle. Otherwise bus_rdata is 0.
- R4: Each trigger lowers the count by one. The trigger that takes the count from 1 to zero loads the reload value in the same edge.
- R5: When a trigger takes the count from 1 to zero with tmr_en=1, tmr_flag is set and tmr_req is high for exactly one cycle. With tmr_en=0, neither happens.
- R6: With evt_mode=0 and tmr_en=1, a trigger occurs every TICK_DIV (default 4) clock edges, and a write restarts the prescaler, so the first trigger is the TICK_DIV-th edge after the write edge. With tmr_en=0 the count does not move.
- R7: With evt_mode=1, each rising edge of ext_pin is one trigger, whatever the value of tmr_en. The count changes on the third clock edge after the pin rises, and the clock alone never moves the count.
- R8: With evt_mode=1, ext_irq stays low whatever ext_pin does.
- R9: With evt_mode=0, ext_irq follows ext_pin two clock edges late, and ext_pin does not change the count.
- R10: tmr_flag stays set until irq_ack is sampled high. If a new zero arrives on the same edge, setting wins.
- R11: A trigger at count 0 wraps the count to 0xFFFF and sets neither tmr_flag nor tmr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, the count on a matching read |
| evt_mode | input | 1 | 1: pin counts events; 0: clock-driven timer and pin is an interrupt |
| tmr_en | input | 1 | Enables the clock timer and the timer interrupt |
| ext_pin | input | 1 | Asynchronous external pin |
| irq_ack | input | 1 | Clears tmr_flag |
| tmr_flag | output | 1 | Sticky timer-interrupt status |
| tmr_req | output | 1 | One-cycle timer interrupt request |
| ext_irq | output | 1 | Pin interrupt request (interrupt mode only) |

## Verification
The results arrive at different times, and each check samples in the cycle where its result is due. A write is visible one edge later. A read is combinational within the cycle. A clock trigger lands on the TICK_DIV-th edge after the write, so after n edges the expected count is the written value minus n/TICK_DIV, with the reload applied at each zero. A pin edge takes three edges to reach the count, and a pin level takes two edges to reach ext_irq. For both, the bench checks one edge early that nothing has changed yet, and then checks the new value on the due edge. The flag and the request are checked on the zero edge, and the request is checked once more one edge later, when it must be low again.

// File: rtl/dec_event_timer.sv
module dec_event_timer #(
  parameter int AW = 16,
  parameter int W = 16,
  parameter logic [AW-1:0] BASE = 16'hFFFA,
  parameter int TICK_DIV = 4,
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [W-1:0]  bus_rdata,
  input  logic          evt_mode,
  input  logic          tmr_en,
  input  logic          ext_pin,
  input  logic          irq_ack,
  output logic          tmr_flag,
  output logic          tmr_req,
  output logic          ext_irq
);

  logic [W-1:0]  cnt, rld;
  logic [PW-1:0] pre;
  logic          pin_s1, pin_s2, pin_d;

  wire hit       = (bus_addr[AW-1:1] == BASE[AW-1:1]);
  wire wr_hit    = bus_wr && hit;
  wire evt_edge  = pin_s2 && !pin_d;
  wire tmr_tick  = !evt_mode && tmr_en && (pre == PW'(TICK_DIV - 1));
  wire trig      = evt_mode ? evt_edge : tmr_tick;
  wire hit_zero  = trig && (cnt == W'(1));
  wire post_irq  = !wr_hit && hit_zero && tmr_en;

  assign bus_rdata = (bus_rd && hit) ? cnt : '0;
  assign ext_irq   = !evt_mode && pin_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      pin_s1 <= ext_pin;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre <= '0;
    else if (wr_hit || evt_mode || !tmr_en || tmr_tick)
      pre <= '0;
    else
      pre <= pre + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else if (wr_hit) begin
      cnt <= bus_wdata;
      rld <= bus_wdata;
    end else if (trig) begin
      cnt <= hit_zero ? rld : cnt - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_flag <= 1'b0;
      tmr_req  <= 1'b0;
    end else begin
      tmr_req <= post_irq;
      if (post_irq)
        tmr_flag <= 1'b1;
      else if (irq_ack)
        tmr_flag <= 1'b0;
    end
  end

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cnt == $past(bus_wdata)) && (rld == $past(bus_wdata)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - W'(1)) || (cnt == rld));

  p_req_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req |-> tmr_flag);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_mode && !tmr_en && !wr_hit) |=> $stable(cnt));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req |=> !tmr_req || (rld == W'(1)));

  p_zero_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && cnt == '0) |=> !tmr_req);

endmodule

// File: tb/dec_event_timer_tb_top.sv
module dec_event_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic evt_mode = 1'b0, tmr_en = 1'b0, ext_pin = 1'b0, irq_ack = 1'b0;
  logic tmr_flag, tmr_req, ext_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dec_event_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .evt_mode(evt_mode), .tmr_en(tmr_en), .ext_pin(ext_pin), .irq_ack(irq_ack),
    .tmr_flag(tmr_flag), .tmr_req(tmr_req), .ext_irq(ext_irq)
  );

  // {written value, edges to wait, expected count, expected flag}, TICK_DIV = 4
  localparam logic [40:0] VEC [0:6] = '{
    {16'd100,   8'd8,  16'd98,    1'b0},
    {16'd10,    8'd40, 16'd10,    1'b1},
    {16'd3,     8'd13, 16'd3,     1'b1},
    {16'd5,     8'd27, 16'd4,     1'b1},
    {16'd0,     8'd4,  16'hFFFF,  1'b0},
    {16'hFFFF,  8'd16, 16'hFFFB,  1'b0},
    {16'd7,     8'd6,  16'd6,     1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic ack);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; irq_ack = ack;
    @(negedge clk);
    bus_wr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(16'hFFFA, v); chk("R1 count", v, 16'h0);
    chk("R1 flag", {15'b0, tmr_flag}, 16'h0);
    chk("R1 req", {15'b0, tmr_req}, 16'h0);
    chk("R1 ext_irq", {15'b0, ext_irq}, 16'h0);

    wr(16'hFFFB, 16'h1234, 1'b0);
    rd(16'hFFFA, v); chk("R2 odd address write", v, 16'h1234);
    repeat (10) @(negedge clk);
    rd(16'hFFFB, v); chk("R6 disabled holds", v, 16'h1234);
    wr(16'hFFFC, 16'h5555, 1'b0);
    rd(16'hFFFA, v); chk("R2 other address ignored", v, 16'h1234);
    rd(16'hFFF8, v); chk("R3 other address reads 0", v, 16'h0);

    tmr_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wr(16'hFFFA, VEC[i][40:25], 1'b1);
      repeat (int'(VEC[i][24:17])) @(negedge clk);
      rd(16'hFFFA, v); chk("R4 R6 R11 table count", v, VEC[i][16:1]);
      chk("R5 R11 table flag", {15'b0, tmr_flag}, {15'b0, VEC[i][0]});
    end

    wr(16'hFFFA, 16'd2, 1'b1);
    repeat (7) @(negedge clk);
    chk("R5 req not early", {15'b0, tmr_req}, 16'h0);
    @(negedge clk);
    chk("R5 req on zero", {15'b0, tmr_req}, 16'h1);
    chk("R5 flag on zero", {15'b0, tmr_flag}, 16'h1);
    @(negedge clk);
    chk("R5 req one cycle", {15'b0, tmr_req}, 16'h0);
    chk("R10 flag held", {15'b0, tmr_flag}, 16'h1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears", {15'b0, tmr_flag}, 16'h0);

    tmr_en = 1'b0; evt_mode = 1'b1;
    wr(16'hFFFA, 16'd2, 1'b1);
    repeat (20) @(negedge clk);
    rd(16'hFFFA, v); chk("R7 no clock counting", v, 16'd2);
    ext_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(16'hFFFA, v); chk("R7 not before third edge", v, 16'd2);
    chk("R8 no ext_irq", {15'b0, ext_irq}, 16'h0);
    @(negedge clk);
    rd(16'hFFFA, v); chk("R7 third edge", v, 16'd1);
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    rd(16'hFFFA, v); chk("R7 one per edge", v, 16'd1);
    pulse();
    rd(16'hFFFA, v); chk("R4 reload in event mode", v, 16'd2);
    chk("R5 disabled no flag", {15'b0, tmr_flag}, 16'h0);
    tmr_en = 1'b1;
    pulse(); pulse();
    rd(16'hFFFA, v); chk("R4 reload again", v, 16'd2);
    chk("R5 enabled flag", {15'b0, tmr_flag}, 16'h1);
    tmr_en = 1'b0;
    wr(16'hFFFA, 16'd0, 1'b1);
    pulse();
    rd(16'hFFFA, v); chk("R11 wrap", v, 16'hFFFF);
    chk("R11 no flag", {15'b0, tmr_flag}, 16'h0);

    evt_mode = 1'b0;
    wr(16'hFFFA, 16'd7, 1'b0);
    ext_pin = 1'b1;
    @(negedge clk);
    chk("R9 irq not after one edge", {15'b0, ext_irq}, 16'h0);
    @(negedge clk);
    chk("R9 irq after two edges", {15'b0, ext_irq}, 16'h1);
    repeat (4) @(negedge clk);
    rd(16'hFFFA, v); chk("R9 pin no count", v, 16'd7);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 irq drops", {15'b0, ext_irq}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule